// File: doc/BRIEF.md
# Power Mode Controller for an 8-bit Microcontroller Core

This block manages the low-power states of a small 8-bit controller. Software writes a mode byte whose bit 0 requests a light sleep and whose bit 1 requests a deep sleep. The block turns that byte into three enables. One gates the CPU clock, one gates the clock of the peripherals (timers, serial unit, interrupt logic), and one lets the oscillator run. In light sleep only the CPU stops. In deep sleep the oscillator stops, so every clock stops.

Light sleep ends on any unmasked interrupt request or on the reset pin. Deep sleep ends only on the reset pin. After deep sleep the oscillator needs a startup interval, and the internal reset is held for a fixed number of oscillator cycles while it settles.

The reset pin is qualified against machine cycles. A machine cycle is a fixed number of oscillator periods, counted by a free-running divider. When light sleep is broken by the reset pin, the CPU clock comes back at once. Writes to internal RAM are blocked from then until the internal reset takes over.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous reset the mode byte reads 0x00. The CPU, peripheral and oscillator enables are all 1. The internal reset and the RAM write inhibit are both 0.
- R2: A write in the running state with bit 0 = 1 and bit 1 = 0 enters light sleep from the next cycle. In light sleep the CPU enable is 0, the peripheral and oscillator enables stay 1, and the read-back equals the written byte.
- R3: A write in the running state with bit 1 = 1 enters deep sleep from the next cycle, whatever bit 0 holds. In deep sleep the CPU, peripheral and oscillator enables are all 0.
- R4: In light sleep, any 1 on an interrupt request line returns the block to running in the next cycle. At that moment bit 0 of the mode byte is cleared and the other bits are kept.
- R5: In deep sleep, interrupt requests have no effect. The enables stay 0 and the mode byte keeps its value.
- R6: In the running state, the internal reset rises only after the reset pin has been high across 2 machine-cycle ticks (12 oscillator periods each). A pulse of 11 cycles or fewer is ignored and leaves the mode byte unchanged. A pulse of 30 cycles asserts the internal reset and clears the mode byte to 0x00. The internal reset falls in the cycle after the pin goes low.
- R7: In light sleep, a high reset pin sets the CPU enable and the RAM write inhibit to 1 from the next cycle. The inhibit stays 1 until the internal reset asserts, and then falls. If the pin falls before qualification, the block returns to light sleep with the mode byte unchanged.
- R8: In deep sleep, a high reset pin sets the oscillator enable and the internal reset to 1 from the next cycle. The internal reset is held for STARTUP_CYC cycles (default 1024) and for as long as the pin stays high. It then falls, with the mode byte at 0x00 and the CPU enable at 1.
- R9: Writes to the mode byte take effect only in the running state. A write made in light or deep sleep leaves the byte and the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reg_we_i | input | 1 | Mode byte write strobe |
| reg_wdata_i | input | REG_W | Mode byte write data |
| irq_i | input | NIRQ | Interrupt requests, already masked by their enables |
| rst_pin_i | input | 1 | External reset pin, synchronous to clk_i |
| reg_rdata_o | output | REG_W | Mode byte read-back |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator run enable |
| int_rst_o | output | 1 | Internal reset to the core |
| ram_we_inhibit_o | output | 1 | Blocks internal RAM writes |

## Verification
The assertions assume that the reset pin is already synchronous to clk_i. They also assume that every interrupt line arrives pre-masked, and that a mode write is a single-cycle strobe. The bench changes every input one nanosecond after a rising edge, so all inputs are stable at each edge. Reset-pin pulses are chosen to lie clearly below or clearly above the qualification window: at most 11 cycles or at least 30 cycles. The result therefore does not depend on the divider phase, which the bench cannot see.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_IDLE_RST,
    ST_PDOWN,
    ST_WAKE,
    ST_RESET
  } pmc_state_e;

  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;
endpackage

// File: rtl/pmc_mcyc_div.sv
module pmc_mcyc_div #(
  parameter int OSC_PER_MCYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(OSC_PER_MCYC);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(OSC_PER_MCYC - 1));
  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R6: machine-cycle ticks are never back to back
  a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int QUAL_MCYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int QW = $clog2(QUAL_MCYC + 1);

  logic [QW-1:0] cnt_q;

  assign hit_o = (cnt_q == QW'(QUAL_MCYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!pin_i)            cnt_q <= '0;
    else if (tick_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R6: a low pin always drops the qualification
  a_r6_low_pin_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_i |=> !hit_o);
endmodule

// File: rtl/pmc_osc_start.sv
module pmc_osc_start #(
  parameter int STARTUP_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic done_o
);
  localparam int SW = $clog2(STARTUP_CYC + 1);

  logic [SW-1:0] cnt_q;

  assign done_o = wake_i && (cnt_q == SW'(STARTUP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!wake_i)  cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R8: startup completes once per wake, then the waker leaves
  a_r8_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NIRQ         = 5,
  parameter int REG_W        = 8,
  parameter int OSC_PER_MCYC = 12,
  parameter int QUAL_MCYC    = 2,
  parameter int STARTUP_CYC  = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             rst_pin_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             int_rst_o,
  output logic             ram_we_inhibit_o
);
  pmc_state_e       state_q, state_d;
  logic [REG_W-1:0] mode_q;
  logic             tick, qual_hit, start_done, any_irq, run_wr;

  assign any_irq = |irq_i;
  assign run_wr  = (state_q == ST_RUN) && reg_we_i && !qual_hit;

  pmc_mcyc_div #(.OSC_PER_MCYC(OSC_PER_MCYC)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (osc_en_o),
    .clr_i (int_rst_o),
    .tick_o(tick)
  );

  pmc_rst_qual #(.QUAL_MCYC(QUAL_MCYC)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (rst_pin_i),
    .tick_i(tick),
    .hit_o (qual_hit)
  );

  pmc_osc_start #(.STARTUP_CYC(STARTUP_CYC)) u_start (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wake_i(state_q == ST_WAKE),
    .done_o(start_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (qual_hit)                         state_d = ST_RESET;
        else if (run_wr && reg_wdata_i[PD_BIT])   state_d = ST_PDOWN;  // deep sleep wins
        else if (run_wr && reg_wdata_i[IDLE_BIT]) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (qual_hit)       state_d = ST_RESET;
        else if (rst_pin_i) state_d = ST_IDLE_RST;
        else if (any_irq)   state_d = ST_RUN;
      end
      ST_IDLE_RST: begin
        if (qual_hit)        state_d = ST_RESET;
        else if (!rst_pin_i) state_d = ST_IDLE;
      end
      ST_PDOWN:    if (rst_pin_i)  state_d = ST_WAKE;
      ST_WAKE:     if (start_done) state_d = ST_RESET;
      ST_RESET:    if (!rst_pin_i) state_d = ST_RUN;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (state_q == ST_RESET || state_q == ST_WAKE || state_d == ST_RESET) begin
      mode_q <= '0;
    end else if (run_wr) begin
      mode_q <= reg_wdata_i;
    end else if (state_q == ST_IDLE && state_d == ST_RUN) begin
      mode_q[IDLE_BIT] <= 1'b0;
    end
  end

  assign reg_rdata_o      = mode_q;
  assign osc_en_o         = (state_q != ST_PDOWN);
  assign int_rst_o        = (state_q == ST_WAKE) || (state_q == ST_RESET);
  assign cpu_clk_en_o     = (state_q == ST_RUN) || (state_q == ST_IDLE_RST) ||
                            (state_q == ST_RESET);
  assign per_clk_en_o     = cpu_clk_en_o || (state_q == ST_IDLE);
  assign ram_we_inhibit_o = (state_q == ST_IDLE_RST);

  // R3: a stopped oscillator implies every gated clock is off
  a_r3_all_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o));

  // R3: both mode bits in one write pick deep sleep
  a_r3_pd_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && reg_we_i && !qual_hit &&
     reg_wdata_i[PD_BIT] && reg_wdata_i[IDLE_BIT]) |=> !osc_en_o);

  // R5: only the reset pin leaves deep sleep
  a_r5_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !rst_pin_i) |=> (!osc_en_o && $stable(reg_rdata_o)));

  // R4: an interrupt ends light sleep and clears the sleep bit
  a_r4_irq_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !rst_pin_i && any_irq) |=>
      (cpu_clk_en_o && !reg_rdata_o[IDLE_BIT]));

  // R7: the inhibit window is only while the CPU runs ahead of internal reset
  a_r7_inhibit_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_inhibit_o |-> (cpu_clk_en_o && !int_rst_o));

  // R6: release of internal reset leaves a cleared mode byte
  a_r6_release_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET && !rst_pin_i) |=> (!int_rst_o && reg_rdata_o == '0));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int NIRQ  = 5;
  localparam int REG_W = 8;
  localparam int SCYC  = 1024;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [REG_W-1:0] reg_wdata_i = '0;
  logic [NIRQ-1:0]  irq_i = '0;
  logic             rst_pin_i = 1'b0;
  logic [REG_W-1:0] reg_rdata_o;
  logic             cpu_clk_en_o, per_clk_en_o, osc_en_o, int_rst_o, ram_we_inhibit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  pwr_mode_ctrl #(.NIRQ(NIRQ), .REG_W(REG_W), .STARTUP_CYC(SCYC)) uut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_we_i        (reg_we_i),
    .reg_wdata_i     (reg_wdata_i),
    .irq_i           (irq_i),
    .rst_pin_i       (rst_pin_i),
    .reg_rdata_o     (reg_rdata_o),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .per_clk_en_o    (per_clk_en_o),
    .osc_en_o        (osc_en_o),
    .int_rst_o       (int_rst_o),
    .ram_we_inhibit_o(ram_we_inhibit_o)
  );

  typedef struct packed {
    logic             we;
    logic [REG_W-1:0] wd;
    logic [NIRQ-1:0]  irq;
    logic             cpu;
    logic             per;
    logic             osc;
    logic [REG_W-1:0] rd;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h01, 5'b00000, 1'b0, 1'b1, 1'b1, 8'h01, 4'd2},  // R2 enter light sleep
    '{1'b0, 8'h00, 5'b00100, 1'b1, 1'b1, 1'b1, 8'h00, 4'd4},  // R4 irq wakes
    '{1'b1, 8'hA1, 5'b00000, 1'b0, 1'b1, 1'b1, 8'hA1, 4'd2},  // R2 other bits stored
    '{1'b1, 8'h00, 5'b00000, 1'b0, 1'b1, 1'b1, 8'hA1, 4'd9},  // R9 write in sleep ignored
    '{1'b0, 8'h00, 5'b10000, 1'b1, 1'b1, 1'b1, 8'hA0, 4'd4},  // R4 only bit 0 cleared
    '{1'b1, 8'h02, 5'b00000, 1'b0, 1'b0, 1'b0, 8'h02, 4'd3},  // R3 deep sleep
    '{1'b0, 8'h00, 5'b11111, 1'b0, 1'b0, 1'b0, 8'h02, 4'd5},  // R5 irq ignored
    '{1'b1, 8'h00, 5'b00000, 1'b0, 1'b0, 1'b0, 8'h02, 4'd9}   // R9 write in deep sleep ignored
  };

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write(logic [REG_W-1:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1", "rdata", 32'(reg_rdata_o), 32'h00);
    chk("R1", "cpu_en", 32'(cpu_clk_en_o), 1);
    chk("R1", "per_en", 32'(per_clk_en_o), 1);
    chk("R1", "osc_en", 32'(osc_en_o), 1);
    chk("R1", "int_rst", 32'(int_rst_o), 0);
    chk("R1", "inhibit", 32'(ram_we_inhibit_o), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      reg_we_i = VECS[i].we; reg_wdata_i = VECS[i].wd; irq_i = VECS[i].irq;
      step(1);
      reg_we_i = 1'b0; reg_wdata_i = '0; irq_i = '0;
      chk(tag, "cpu_en", 32'(cpu_clk_en_o), 32'(VECS[i].cpu));
      chk(tag, "per_en", 32'(per_clk_en_o), 32'(VECS[i].per));
      chk(tag, "osc_en", 32'(osc_en_o), 32'(VECS[i].osc));
      chk(tag, "rdata", 32'(reg_rdata_o), 32'(VECS[i].rd));
    end

    // R8 wake from deep sleep with a short pin pulse
    rst_pin_i = 1'b1;
    step(1);
    chk("R8", "osc_en", 32'(osc_en_o), 1);
    chk("R8", "int_rst", 32'(int_rst_o), 1);
    chk("R8", "cpu_en", 32'(cpu_clk_en_o), 0);
    step(3);
    rst_pin_i = 1'b0;
    step(SCYC - 10);
    chk("R8", "int_rst held in startup", 32'(int_rst_o), 1);
    step(8);
    chk("R8", "int_rst released", 32'(int_rst_o), 0);
    chk("R8", "rdata", 32'(reg_rdata_o), 32'h00);
    chk("R8", "cpu_en", 32'(cpu_clk_en_o), 1);

    // R3 both bits set, then R8 wake with the pin held past startup
    write(8'h03);
    chk("R3", "osc_en", 32'(osc_en_o), 0);
    chk("R3", "cpu_en", 32'(cpu_clk_en_o), 0);
    chk("R3", "per_en", 32'(per_clk_en_o), 0);
    rst_pin_i = 1'b1;
    step(SCYC + 20);
    chk("R8", "int_rst held by pin", 32'(int_rst_o), 1);
    rst_pin_i = 1'b0;
    step(1);
    chk("R8", "int_rst after pin low", 32'(int_rst_o), 0);

    // R6 reset pin qualification in the running state
    write(8'h40);
    chk("R6", "rdata before pulse", 32'(reg_rdata_o), 32'h40);
    rst_pin_i = 1'b1;
    step(11);
    chk("R6", "short pulse int_rst", 32'(int_rst_o), 0);
    rst_pin_i = 1'b0;
    step(1);
    chk("R6", "short pulse rdata", 32'(reg_rdata_o), 32'h40);
    rst_pin_i = 1'b1;
    step(30);
    chk("R6", "long pulse int_rst", 32'(int_rst_o), 1);
    chk("R6", "long pulse rdata", 32'(reg_rdata_o), 32'h00);
    rst_pin_i = 1'b0;
    step(1);
    chk("R6", "release", 32'(int_rst_o), 0);

    // R7 reset pin during light sleep
    write(8'h01);
    rst_pin_i = 1'b1;
    step(1);
    chk("R7", "cpu_en", 32'(cpu_clk_en_o), 1);
    chk("R7", "inhibit", 32'(ram_we_inhibit_o), 1);
    chk("R7", "int_rst", 32'(int_rst_o), 0);
    step(3);
    rst_pin_i = 1'b0;
    step(1);
    chk("R7", "back to sleep cpu_en", 32'(cpu_clk_en_o), 0);
    chk("R7", "back to sleep inhibit", 32'(ram_we_inhibit_o), 0);
    chk("R7", "back to sleep rdata", 32'(reg_rdata_o), 32'h01);
    rst_pin_i = 1'b1;
    step(1);
    chk("R7", "inhibit again", 32'(ram_we_inhibit_o), 1);
    step(30);
    chk("R7", "int_rst took over", 32'(int_rst_o), 1);
    chk("R7", "inhibit dropped", 32'(ram_we_inhibit_o), 0);
    rst_pin_i = 1'b0;
    step(1);
    chk("R7", "rdata after reset", 32'(reg_rdata_o), 32'h00);
    chk("R7", "cpu_en after reset", 32'(cpu_clk_en_o), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule